// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that software controls only by writing magic numbers to a key register on a small word-addressed register bus. One key opens the divider-select and reload registers for writing. Another key starts the watchdog, and once it has started no write can stop it. A third key refreshes the down-counter. If software stops refreshing, the counter runs down to zero and the block raises a reset request for one cycle.

The counter does not advance on the bus clock. It advances on `tick_en`, a qualifier that stands in for a separate low-speed clock. Every `tick_en` pulse feeds a prescaler that divides by a power of two. Every prescaler output step decrements the counter.

A new divider or reload value does not reach the counting logic at once. It is applied only after a fixed number of low-speed ticks. Until then, a pending flag in the status register stays set.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the read-back values are: divider code at offset 0x4 reads 0, reload at offset 0x8 reads 0xFFF, status at offset 0xC reads 0, and the key offset 0x0 reads 0. `rst_req` is low and the counter is stopped.
- R2: A write of exactly 0x0000_5555 to offset 0x0 opens the divider (offset 0x4, 3 bits) and reload (offset 0x8, 12 bits) registers for writing. Each accepted write is visible on the next read.
- R3: A write of any other value to offset 0x0 closes the registers again. While the registers are closed, a write to offset 0x4 or 0x8 leaves both the read-back value and the status flags unchanged.
- R4: A write of exactly 0x0000_CCCC to offset 0x0 starts the watchdog. It loads the counter from the applied reload value and clears the prescaler. Only `rst_n` can stop the watchdog once it has started.
- R5: A write of exactly 0x0000_AAAA to offset 0x0 reloads the counter from the applied reload value and clears the prescaler, which restarts the full timeout.
- R6: Divider code c selects one counter step every 4·2^c `tick_en` pulses for c = 0..5. Codes 6 and 7 both select 256.
- R7: With `tick_en` held high, `rst_req` is high in the D·(R+1)-th cycle after the clock edge that accepts a start or refresh key. Here D is the divisor and R is the applied reload value.
- R8: `rst_req` lasts exactly one cycle. The counter then reloads itself, so the next request follows D·(R+1) cycles later if there is no refresh.
- R9: Status bit 0 shows a pending divider update and bit 1 shows a pending reload update. An accepted write sets its bit. The bit clears on the 3rd `tick_en` pulse after the most recent write, and it holds while `tick_en` is low.
- R10: The counting logic uses a new divider or reload value only from the moment its pending bit clears. A start key that arrives while a reload update is pending loads the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per low-speed clock period |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the address, zero when not selected |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench goes after the exact expiry cycle for several divider codes, including code 7 aliasing to 256. A prescaler that drops the aliasing, or is off by one in its terminal count, would move the request by D or by a whole period. Lock tests cover a re-lock by a foreign key and a write to a closed register; a design that ignored the lock would show the new value and raise a pending flag. The delayed-apply test starts the counter while a reload update is still waiting. A design that applied values straight from the bus would expire at 40 cycles instead of 16. The pending flag is also held with `tick_en` low, so a flag timed on the bus clock would clear too early.

// File: rtl/wdt_pkg.sv
// Shared constants for the key-protected watchdog: key codes and register
// offsets. Assumes a 32-bit data bus and byte offsets on a 4-bit address.
package wdt_pkg;
    localparam logic [31:0] KEY_OPEN  = 32'h0000_5555;
    localparam logic [31:0] KEY_START = 32'h0000_CCCC;
    localparam logic [31:0] KEY_FEED  = 32'h0000_AAAA;

    localparam logic [3:0] OFS_KEY  = 4'h0;
    localparam logic [3:0] OFS_DIV  = 4'h4;
    localparam logic [3:0] OFS_LOAD = 4'h8;
    localparam logic [3:0] OFS_STAT = 4'hC;
endpackage

// File: rtl/wdt_apply_sync.sv
// Holds the value the counting logic uses and moves a freshly written bus
// value into it after SYNC_TICKS low-speed ticks. It raises a pending flag
// in the meantime. A new write restarts the wait. Assumes new_val is stable
// while pending is set, except in the cycle of a new load.
module wdt_apply_sync #(
    parameter int           W          = 12,
    parameter int           SYNC_TICKS = 3,
    parameter logic [W-1:0] RESET_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         load,
    input  logic [W-1:0] new_val,
    output logic         pending,
    output logic [W-1:0] applied
);
    localparam int CW = $clog2(SYNC_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(SYNC_TICKS - 1);

    logic [CW-1:0] wait_cnt;

    // Count low-speed ticks while pending, then apply the value and clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            wait_cnt <= '0;
            applied  <= RESET_VAL;
        end else if (load) begin
            pending  <= 1'b1;
            wait_cnt <= '0;
        end else if (pending && tick_en) begin
            if (wait_cnt == LAST) begin
                applied <= new_val;
                pending <= 1'b0;
            end else begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_key_regs.sv
// Decodes key writes and holds the lockable divider and reload registers.
// Each register feeds an apply stage that delays the value until it reaches
// the counting logic. Only an exact match of all 32 data bits counts as a key.
module wdt_key_regs #(
    parameter int CODE_W     = 3,
    parameter int CNT_W      = 12,
    parameter int SYNC_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              unlocked,
    output logic [CODE_W-1:0] div_q,
    output logic [CNT_W-1:0]  load_q,
    output logic [1:0]        stat,
    output logic [CODE_W-1:0] div_applied,
    output logic [CNT_W-1:0]  load_applied,
    output logic              start_pulse,
    output logic              feed_pulse
);
    import wdt_pkg::*;

    logic wr_key, wr_div, wr_load;

    // Write strobes per register; the protected ones are gated by the lock.
    always_comb begin
        wr_key      = bus_sel && bus_wr && (bus_addr == OFS_KEY);
        wr_div      = bus_sel && bus_wr && (bus_addr == OFS_DIV)  && unlocked;
        wr_load     = bus_sel && bus_wr && (bus_addr == OFS_LOAD) && unlocked;
        start_pulse = wr_key && (bus_wdata == KEY_START);
        feed_pulse  = wr_key && (bus_wdata == KEY_FEED);
    end

    // Lock state: any key write sets it open only for the unlock value.
    always_ff @(posedge clk) begin
        if (!rst_n)      unlocked <= 1'b0;
        else if (wr_key) unlocked <= (bus_wdata == KEY_OPEN);
    end

    // Bus-side copies of the protected registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            load_q <= '1;
        end else begin
            if (wr_div)  div_q  <= bus_wdata[CODE_W-1:0];
            if (wr_load) load_q <= bus_wdata[CNT_W-1:0];
        end
    end

    wdt_apply_sync #(
        .W(CODE_W), .SYNC_TICKS(SYNC_TICKS), .RESET_VAL('0)
    ) u_div_sync (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(wr_div),
        .new_val(div_q), .pending(stat[0]), .applied(div_applied)
    );

    wdt_apply_sync #(
        .W(CNT_W), .SYNC_TICKS(SYNC_TICKS), .RESET_VAL('1)
    ) u_load_sync (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(wr_load),
        .new_val(load_q), .pending(stat[1]), .applied(load_applied)
    );
endmodule

// File: rtl/wdt_prescaler.sv
// Divides low-speed ticks by 2^(code+2), capped at 2^DIV_W. It gives one
// step pulse per period while run is high, and restart clears the phase.
// Assumes DIV_W >= 2.
module wdt_prescaler #(
    parameter int CODE_W = 3,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick_en,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              step
);
    logic [DIV_W-1:0] phase;
    logic [DIV_W-1:0] term;
    int               shift;

    // Terminal phase for the selected divisor, clamped at the widest one.
    always_comb begin
        shift = int'(code) + 2;
        if (shift > DIV_W) shift = DIV_W;
        term = DIV_W'((64'd1 << shift) - 64'd1);
        step = run && tick_en && (phase >= term);
    end

    // Phase counter over low-speed ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)              phase <= '0;
        else if (restart)        phase <= '0;
        else if (run && tick_en) phase <= step ? '0 : phase + 1'b1;
    end
endmodule

// File: rtl/wdt_down_counter.sv
// Down-counter for the timeout. It loads on a start or refresh, steps on each
// prescaler pulse, and at zero it raises a one-cycle request and reloads itself.
module wdt_down_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    // Count down; wrap to the reload value after reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '1;
        else if (load) cnt <= reload_val;
        else if (step) cnt <= (cnt == '0) ? reload_val : cnt - 1'b1;
    end

    // Registered request, one cycle per expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) expire <= 1'b0;
        else        expire <= step && !load && (cnt == '0);
    end
endmodule

// File: rtl/keyed_wdt.sv
// Top of the key-protected watchdog. It joins the key and register logic,
// the prescaler and the down-counter, and holds the run flag, which only
// reset clears. Register reads are combinational on the address.
module keyed_wdt #(
    parameter int CODE_W     = 3,
    parameter int DIV_W      = 8,
    parameter int CNT_W      = 12,
    parameter int SYNC_TICKS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        rst_req
);
    import wdt_pkg::*;

    logic              unlocked;
    logic [CODE_W-1:0] div_q, div_applied;
    logic [CNT_W-1:0]  load_q, load_applied;
    logic [1:0]        stat;
    logic              start_pulse, feed_pulse, step, enabled;

    wdt_key_regs #(
        .CODE_W(CODE_W), .CNT_W(CNT_W), .SYNC_TICKS(SYNC_TICKS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .unlocked(unlocked),
        .div_q(div_q), .load_q(load_q), .stat(stat),
        .div_applied(div_applied), .load_applied(load_applied),
        .start_pulse(start_pulse), .feed_pulse(feed_pulse)
    );

    // Run flag: set by the start key, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           enabled <= 1'b0;
        else if (start_pulse) enabled <= 1'b1;
    end

    wdt_prescaler #(.CODE_W(CODE_W), .DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(enabled), .tick_en(tick_en),
        .restart(start_pulse || feed_pulse), .code(div_applied), .step(step)
    );

    wdt_down_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .step(step),
        .load(start_pulse || feed_pulse), .reload_val(load_applied),
        .expire(rst_req)
    );

    // Read mux over the bus-side register copies.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFS_DIV:  bus_rdata = 32'(div_q);
                OFS_LOAD: bus_rdata = 32'(load_q);
                OFS_STAT: bus_rdata = 32'(stat);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/keyed_wdt_checker.sv
// Temporal checks on the watchdog, bound to every keyed_wdt instance.
module keyed_wdt_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             rst_req,
    input logic             enabled,
    input logic             unlocked,
    input logic [CNT_W-1:0] load_q,
    input logic [1:0]       stat
);
    logic wr_load_any, wr_key_any;
    assign wr_load_any = bus_sel && bus_wr && (bus_addr == 4'h8);
    assign wr_key_any  = bus_sel && bus_wr && (bus_addr == 4'h0);

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R8
    AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> enabled); // R7
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |=> enabled); // R4
    AST_LOCKED_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load_any && !unlocked) |=> $stable(load_q)); // R3
    AST_LOCKED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load_any && !unlocked && !stat[1]) |=> !stat[1]); // R3
    AST_FOREIGN_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_key_any && bus_wdata != 32'h0000_5555) |=> !unlocked); // R3
    AST_OPEN_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load_any && unlocked) |=> stat[1]); // R9
endmodule

bind keyed_wdt keyed_wdt_checker #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rst_req(rst_req),
    .enabled(enabled), .unlocked(unlocked), .load_q(load_q), .stat(stat)
);

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    keyed_wdt i_keyed_wdt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG_CYCLES) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG_CYCLES);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Count edges until rst_req is seen, starting the count at init.
    task automatic measure(input int init, input int limit, output int n);
        n = init;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (rst_req || n > limit) break;
        end
    endtask

    // Open, program, and wait (tick_en high) until both values are applied.
    task automatic setup(input int code, input int reload);
        logic [31:0] s;
        @(negedge clk);
        tick_en = 1'b1;
        bus_write(4'h0, 32'h5555);
        bus_write(4'h4, 32'(code));
        bus_write(4'h8, 32'(reload));
        repeat (6) @(negedge clk);
        bus_read(4'hC, s);
        check("R9 applied after ticks", s, 0);
    endtask

    task automatic t_reset_values();
        logic [31:0] d;
        do_reset();
        check("R1 rst_req low", rst_req, 0);
        bus_read(4'h4, d); check("R1 divider", d, 0);
        bus_read(4'h8, d); check("R1 reload", d, 12'hFFF);
        bus_read(4'hC, d); check("R1 status", d, 0);
        bus_read(4'h0, d); check("R1 key reads zero", d, 0);
        tick_en = 1'b1;
        repeat (300) @(negedge clk);
        check("R1 idle without start", rst_req, 0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        do_reset();
        bus_write(4'h8, 32'h123);
        bus_read(4'h8, d); check("R3 locked reload ignored", d, 12'hFFF);
        bus_read(4'hC, d); check("R3 locked write no flag", d, 0);
        bus_write(4'h0, 32'h5555);
        bus_write(4'h0, 32'h1234);
        bus_write(4'h8, 32'h123);
        bus_read(4'h8, d); check("R3 relocked by foreign key", d, 12'hFFF);
        bus_write(4'h0, 32'h0001_5555);
        bus_write(4'h4, 32'h5);
        bus_read(4'h4, d); check("R3 upper bits spoil key", d, 0);
        bus_write(4'h0, 32'h5555);
        bus_write(4'h8, 32'h123);
        bus_write(4'h4, 32'h5);
        bus_read(4'h8, d); check("R2 reload written", d, 12'h123);
        bus_read(4'h4, d); check("R2 divider written", d, 5);
        bus_read(4'hC, d); check("R9 both flags pending", d, 3);
    endtask

    task automatic t_flags();
        logic [31:0] d;
        do_reset();
        bus_write(4'h0, 32'h5555);
        bus_write(4'h8, 32'h7);
        repeat (10) @(negedge clk);
        bus_read(4'hC, d); check("R9 flag holds without ticks", d, 2);
        tick_en = 1'b1;                      // set at a negedge
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = 4'hC; #1;
        check("R9 flag after two ticks", bus_rdata, 2);
        bus_sel = 1'b0;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b1; bus_addr = 4'hC; #1;
        check("R9 flag clears on third tick", bus_rdata, 0);
        bus_sel = 1'b0;
    endtask

    task automatic t_timeout_period();
        int n;
        do_reset();
        setup(0, 9);
        bus_write(4'h0, 32'hCCCC);
        measure(0, 200, n);
        check("R7 first expiry div4 reload9", n, 40);
        @(posedge clk); @(negedge clk);
        check("R8 request one cycle", rst_req, 0);
        measure(1, 200, n);
        check("R8 automatic second expiry", n, 40);
    endtask

    task automatic t_codes();
        int n;
        do_reset(); setup(2, 1);
        bus_write(4'h0, 32'hCCCC);
        measure(0, 2000, n); check("R6 code 2 divide 16", n, 32);
        do_reset(); setup(5, 0);
        bus_write(4'h0, 32'hCCCC);
        measure(0, 2000, n); check("R6 code 5 divide 128", n, 128);
        do_reset(); setup(7, 0);
        bus_write(4'h0, 32'hCCCC);
        measure(0, 2000, n); check("R6 code 7 divide 256", n, 256);
        do_reset(); setup(6, 1);
        bus_write(4'h0, 32'hCCCC);
        measure(0, 2000, n); check("R6 code 6 divide 256", n, 512);
    endtask

    task automatic t_feed();
        int n;
        int early;
        early = 0;
        do_reset(); setup(0, 9);
        bus_write(4'h0, 32'hCCCC);
        repeat (30) begin
            @(negedge clk);
            if (rst_req) early++;
        end
        bus_write(4'h0, 32'hAAAA);
        check("R5 no expiry before refresh", early, 0);
        measure(0, 200, n);
        check("R5 refresh restarts period", n, 40);
    endtask

    task automatic t_sticky();
        int n;
        do_reset(); setup(0, 9);
        bus_write(4'h0, 32'hCCCC);
        bus_write(4'h0, 32'h0000);
        bus_write(4'h0, 32'h5555);
        bus_write(4'h0, 32'hFFFF);
        measure(0, 200, n);
        check("R4 still expires after other keys", rst_req, 1);
        measure(0, 200, n);
        check("R4 keeps running period", n, 40);
    endtask

    task automatic t_delayed_apply();
        int n;
        logic [31:0] d;
        do_reset(); setup(0, 3);
        @(negedge clk); tick_en = 1'b0;
        bus_write(4'h0, 32'h5555);
        bus_write(4'h8, 32'h9);
        bus_read(4'hC, d); check("R9 pending before start", d, 2);
        bus_write(4'h0, 32'hCCCC);
        tick_en = 1'b1;
        measure(0, 200, n);
        check("R10 start uses previous reload", n, 16);
        measure(0, 200, n);
        check("R10 reload after apply", n, 40);
    endtask

    initial begin
        t_reset_values();
        t_lock();
        t_flags();
        t_timeout_period();
        t_codes();
        t_feed();
        t_sticky();
        t_delayed_apply();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule